// File: doc/BRIEF.md
# Multiply/Divide Unit with HI/LO Result Registers

This block is a sequential 32-bit arithmetic engine for integer multiplication and division, signed or unsigned. It owns two result registers, HI and LO. A command is accepted in a single cycle. The unit then stays busy for a number of cycles that imitates the timing of a classic in-order processor core. A multiply places the full 64-bit product in HI:LO. A divide leaves the quotient in LO and the remainder in HI. A zero divisor and the one signed overflow case do not trap. They produce fixed substitute values.

A single command port carries all eight operations. Those are the two reads, the two direct writes, and the four arithmetic starts. A read or a direct write presented while the engine is busy raises `stall`. The caller holds the command until `stall` falls, and the command takes effect in that cycle. A new arithmetic command is never stalled. If it arrives while an older one is still running, the older one is abandoned and the new one starts with its own latency. The arithmetic itself is combinational and is captured at issue. The latency is modelled by a down-counter, and the result is committed to HI/LO when that counter expires.

Top module: `mdu_top`

## Requirements
- R1: After reset HI and LO are zero, `busy` is low, and a read returns zero without stalling.
- R2: The `op_code` encoding is 0=read HI, 1=read LO, 2=write HI, 3=write LO, 4=signed multiply, 5=unsigned multiply, 6=signed divide, 7=unsigned divide. A multiply leaves the 64-bit product of `rs` and `rt` with its upper half in HI and its lower half in LO.
- R3: An unsigned multiply keeps `busy` high for 6 cycles when `rs` < 0x800, 9 cycles when `rs` < 0x100000, and 13 cycles otherwise.
- R4: A signed multiply keeps `busy` high for 6 cycles when `rs` lies in [-0x800, 0x7FF], 9 cycles when it lies in [-0x100000, 0xFFFFF], and 13 cycles otherwise.
- R5: A divide keeps `busy` high for 36 cycles whatever the operands. It leaves the quotient in LO and the remainder in HI. Signed division truncates toward zero, and the remainder carries the sign of the dividend.
- R6: With `rt` = 0, HI receives `rs`. LO receives 0xFFFFFFFF for the unsigned divide. For the signed divide, LO receives 0xFFFFFFFF when `rs` is non-negative and 0x00000001 when `rs` is negative.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R8: A read or write of HI/LO presented while `busy` is high asserts `stall` in every such cycle. `stall` stays low whenever `busy` is low. The read data is the committed result in the first cycle without a stall.
- R9: A direct write copies `rs` into HI or LO. If it is held through a stall, it is applied on the clock edge after `stall` falls, on top of the committed result. HI and LO change only through a commit or a direct write.
- R10: An arithmetic command issued while `busy` is high is not stalled. It discards the running operation, and the latency restarts from the new command's own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 3 | Operation select, encoding in R2 |
| rs | input | 32 | First operand, dividend, or value for a direct write |
| rt | input | 32 | Second operand or divisor |
| rd_data | output | 32 | HI or LO as selected by a read command |
| stall | output | 1 | Read or write held off by a running operation |
| busy | output | 1 | An arithmetic operation is in flight |

## Verification
The hardest situations to reach are the ones where a command meets a running operation. One is a direct write held through the whole stall and landing on top of the freshly committed result. The other is a second multiply that cuts into a long divide and must replace both its result and its remaining latency. The bench builds both on purpose. It issues the first operation, then presents the colliding command a chosen number of cycles later. It counts stall cycles from the ports. After that it reads both halves back. The latency boundaries are reached with operands placed exactly on each side of the fast/medium/slow thresholds, in both signed and unsigned form.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_RD_HI  = 3'd0,
    OP_RD_LO  = 3'd1,
    OP_WR_HI  = 3'd2,
    OP_WR_LO  = 3'd3,
    OP_MUL_S  = 3'd4,
    OP_MUL_U  = 3'd5,
    OP_DIV_S  = 3'd6,
    OP_DIV_U  = 3'd7
  } mdu_op_e;

endpackage

// File: rtl/mdu_lat.sv
// Latency selector: emulated cycle count of an operation from its operand size.
module mdu_lat #(
  parameter int W         = 32,
  parameter int FAST_BITS = 11,
  parameter int MED_BITS  = 20,
  parameter int LAT_FAST  = 6,
  parameter int LAT_MED   = 9,
  parameter int LAT_SLOW  = 13,
  parameter int LAT_DIV   = 36,
  localparam int CW       = $clog2(LAT_DIV + 1)
) (
  input  logic [W-1:0]  rs,
  input  logic          is_signed,
  input  logic          is_div,
  output logic [CW-1:0] lat
);

  logic fast_ok;
  logic med_ok;

  // A value fits a range when every bit above the threshold matches the
  // sign (signed) or is zero (unsigned).
  always_comb begin
    if (is_signed) begin
      fast_ok = (&rs[W-1:FAST_BITS]) | ~(|rs[W-1:FAST_BITS]);
      med_ok  = (&rs[W-1:MED_BITS])  | ~(|rs[W-1:MED_BITS]);
    end else begin
      fast_ok = ~(|rs[W-1:FAST_BITS]);
      med_ok  = ~(|rs[W-1:MED_BITS]);
    end
  end

  always_comb begin
    if (is_div)       lat = CW'(LAT_DIV);
    else if (fast_ok) lat = CW'(LAT_FAST);
    else if (med_ok)  lat = CW'(LAT_MED);
    else              lat = CW'(LAT_SLOW);
  end

endmodule

// File: rtl/mdu_calc.sv
// Combinational arithmetic: product, or quotient/remainder with defined
// substitutes for a zero divisor.
module mdu_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] rs,
  input  logic [W-1:0] rt,
  input  logic         is_signed,
  input  logic         is_div,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);

  logic [2*W-1:0] mul_a;
  logic [2*W-1:0] mul_b;
  logic [2*W-1:0] product;
  logic           neg_a;
  logic           neg_b;
  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic [W-1:0]   divisor;
  logic [W-1:0]   uq;
  logic [W-1:0]   ur;
  logic [W-1:0]   quot;
  logic [W-1:0]   rem;
  logic           div_zero;

  // Truncated 2W-bit product of sign- or zero-extended operands.
  always_comb begin
    mul_a   = is_signed ? {{W{rs[W-1]}}, rs} : {{W{1'b0}}, rs};
    mul_b   = is_signed ? {{W{rt[W-1]}}, rt} : {{W{1'b0}}, rt};
    product = mul_a * mul_b;
  end

  // One unsigned divider on magnitudes; signs are restored afterwards.
  // Overflow case -2^(W-1) / -1 falls out as quotient 2^(W-1), remainder 0.
  always_comb begin
    neg_a    = is_signed & rs[W-1];
    neg_b    = is_signed & rt[W-1];
    mag_a    = neg_a ? (~rs + 1'b1) : rs;
    mag_b    = neg_b ? (~rt + 1'b1) : rt;
    div_zero = (rt == '0);
    divisor  = div_zero ? W'(1) : mag_b;
    uq       = mag_a / divisor;
    ur       = mag_a % divisor;
    quot     = (neg_a ^ neg_b) ? (~uq + 1'b1) : uq;
    rem      = neg_a ? (~ur + 1'b1) : ur;
  end

  always_comb begin
    if (!is_div) begin
      res_hi = product[2*W-1:W];
      res_lo = product[W-1:0];
    end else if (div_zero) begin
      res_hi = rs;
      res_lo = neg_a ? W'(1) : '1;
    end else begin
      res_hi = rem;
      res_lo = quot;
    end
  end

endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int W         = 32,
  parameter int FAST_BITS = 11,
  parameter int MED_BITS  = 20,
  parameter int LAT_FAST  = 6,
  parameter int LAT_MED   = 9,
  parameter int LAT_SLOW  = 13,
  parameter int LAT_DIV   = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] rs,
  input  logic [W-1:0] rt,
  output logic [W-1:0] rd_data,
  output logic         stall,
  output logic         busy
);

  localparam int CW = $clog2(LAT_DIV + 1);

  mdu_op_e      op;
  logic         do_arith;
  logic         do_move;
  logic         is_signed;
  logic         is_div;
  logic [CW-1:0] lat;
  logic [W-1:0] res_hi;
  logic [W-1:0] res_lo;

  logic [W-1:0]  hi_q, hi_d;
  logic [W-1:0]  lo_q, lo_d;
  logic [W-1:0]  pend_hi_q, pend_lo_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hi_en, lo_en, pend_en, cnt_en;

  assign op        = mdu_op_e'(op_code);
  assign is_signed = ~op_code[0];
  assign is_div    = op_code[1];

  mdu_lat #(
    .W(W), .FAST_BITS(FAST_BITS), .MED_BITS(MED_BITS),
    .LAT_FAST(LAT_FAST), .LAT_MED(LAT_MED), .LAT_SLOW(LAT_SLOW),
    .LAT_DIV(LAT_DIV)
  ) u_lat (
    .rs(rs), .is_signed(is_signed), .is_div(is_div), .lat(lat)
  );

  mdu_calc #(.W(W)) u_calc (
    .rs(rs), .rt(rt), .is_signed(is_signed), .is_div(is_div),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  assign busy     = (cnt_q != '0);
  assign do_arith = op_valid & op_code[2];
  assign do_move  = op_valid & ((op == OP_WR_HI) | (op == OP_WR_LO));
  assign stall    = op_valid & ~op_code[2] & busy;
  assign rd_data  = (op == OP_RD_HI) ? hi_q : lo_q;

  // Next-state logic.
  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    hi_en   = 1'b0;
    lo_en   = 1'b0;
    pend_en = 1'b0;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    if (do_arith) begin
      pend_en = 1'b1;
      cnt_en  = 1'b1;
      cnt_d   = lat;
    end else if (busy) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        hi_en = 1'b1;
        lo_en = 1'b1;
        hi_d  = pend_hi_q;
        lo_d  = pend_lo_q;
      end
    end else if (do_move) begin
      if (op == OP_WR_HI) begin
        hi_en = 1'b1;
        hi_d  = rs;
      end else begin
        lo_en = 1'b1;
        lo_d  = rs;
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      pend_hi_q <= '0;
      pend_lo_q <= '0;
      cnt_q     <= '0;
    end else begin
      if (hi_en)   hi_q <= hi_d;
      if (lo_en)   lo_q <= lo_d;
      if (pend_en) begin
        pend_hi_q <= res_hi;
        pend_lo_q <= res_lo;
      end
      if (cnt_en)  cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W       = 32,
  parameter int LAT_DIV = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic         busy,
  input logic         stall,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);

  localparam int KW = $clog2(LAT_DIV + 2);

  logic          issue;
  logic          move;
  logic [KW-1:0] since_issue;

  assign issue = op_valid & op_code[2];
  assign move  = op_valid & (op_code[2:1] == 2'b01);

  // Cycles spent busy since the last arithmetic issue, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_issue <= '0;
    else if (issue)
      since_issue <= '0;
    else if (busy && since_issue != KW'(LAT_DIV + 1))
      since_issue <= since_issue + 1'b1;
  end

  // R1: nothing in flight right after reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy);

  // R8: a stall only ever happens while an operation runs
  p_stall_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);

  // R8: reads and writes presented during a run are held off
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_valid && !op_code[2]) |-> stall);

  // R10: arithmetic commands are never stalled and always start a run
  p_issue_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!stall ##1 busy));

  // R5: no run lasts longer than the divide latency
  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (since_issue < KW'(LAT_DIV)));

  // R9: result registers hold when idle and no direct write is applied
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !move) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind mdu_top mdu_checker #(.W(W), .LAT_DIV(LAT_DIV)) u_mdu_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .busy(busy), .stall(stall), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/mdu_top_bench.sv
module mdu_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [7:0]  lat;
    logic [7:0]  req;
  } vec_t;

  // req: requirement number checked by the vector (latency side)
  localparam vec_t VECS [NV] = '{
    '{3'd5, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F, 8'd6,  8'd3},
    '{3'd5, 32'h000007FF, 32'h000007FF, 32'h00000000, 32'h003FF001, 8'd6,  8'd3},
    '{3'd5, 32'h00000800, 32'h00000002, 32'h00000000, 32'h00001000, 8'd9,  8'd3},
    '{3'd5, 32'h000FFFFF, 32'h00000001, 32'h00000000, 32'h000FFFFF, 8'd9,  8'd3},
    '{3'd5, 32'h00100000, 32'h00001000, 32'h00000001, 32'h00000000, 8'd13, 8'd3},
    '{3'd5, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'hFFFFFFFF, 8'd13, 8'd3},
    '{3'd5, 32'hFFFFF800, 32'h00000001, 32'h00000000, 32'hFFFFF800, 8'd13, 8'd3},
    '{3'd4, 32'hFFFFFFFF, 32'h00000005, 32'hFFFFFFFF, 32'hFFFFFFFB, 8'd6,  8'd4},
    '{3'd4, 32'hFFFFF800, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFF000, 8'd6,  8'd4},
    '{3'd4, 32'h000007FF, 32'h00000001, 32'h00000000, 32'h000007FF, 8'd6,  8'd4},
    '{3'd4, 32'hFFFFF7FF, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFF7FF, 8'd9,  8'd4},
    '{3'd4, 32'h00000800, 32'h00000001, 32'h00000000, 32'h00000800, 8'd9,  8'd4},
    '{3'd4, 32'hFFF00000, 32'h00000001, 32'hFFFFFFFF, 32'hFFF00000, 8'd9,  8'd4},
    '{3'd4, 32'hFFEFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'hFFEFFFFF, 8'd13, 8'd4},
    '{3'd4, 32'h00100000, 32'h00000001, 32'h00000000, 32'h00100000, 8'd13, 8'd4},
    '{3'd4, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000, 8'd13, 8'd4},
    '{3'd7, 32'h00000064, 32'h00000007, 32'h00000002, 32'h0000000E, 8'd36, 8'd5},
    '{3'd6, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD, 8'd36, 8'd5},
    '{3'd6, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD, 8'd36, 8'd5},
    '{3'd7, 32'h00000005, 32'h00000000, 32'h00000005, 32'hFFFFFFFF, 8'd36, 8'd6},
    '{3'd6, 32'h00000005, 32'h00000000, 32'h00000005, 32'hFFFFFFFF, 8'd36, 8'd6},
    '{3'd6, 32'hFFFFFFFB, 32'h00000000, 32'hFFFFFFFB, 32'h00000001, 8'd36, 8'd6},
    '{3'd6, 32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 8'd36, 8'd6},
    '{3'd6, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 8'd36, 8'd7}
  };

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] rs;
  logic [31:0] rt;
  logic [31:0] rd_data;
  logic        stall;
  logic        busy;

  int total;
  int bad;
  bit done;

  mdu_top u_mdu_top (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .rs(rs), .rt(rt), .rd_data(rd_data), .stall(stall), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one command for one cycle; starts and ends just after a negedge.
  task automatic issue(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b);
    op_valid = 1'b1;
    op_code  = op;
    rs       = a;
    rt       = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Present a read or write, hold it through any stall, count stall cycles.
  task automatic hold_cmd(input logic [2:0] op, input logic [31:0] a,
                          output int nstall, output logic [31:0] data);
    op_valid = 1'b1;
    op_code  = op;
    rs       = a;
    nstall   = 0;
    #1;
    while (stall) begin
      @(negedge clk);
      #1;
      nstall++;
    end
    data = rd_data;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    int n;
    logic [31:0] d;
    total    = 0;
    bad      = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = 3'd0;
    rs       = '0;
    rt       = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    check("R1 busy after reset", 32'(busy), 32'd0);
    hold_cmd(3'd0, 32'h0, n, d);
    check("R1 HI after reset", d, 32'h0);
    check("R1 no stall on HI read", 32'(n), 32'd0);
    hold_cmd(3'd1, 32'h0, n, d);
    check("R1 LO after reset", d, 32'h0);

    // Vector walk: R2 results, R3/R4/R5 latency, R5/R6/R7 divide values
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].b);
      hold_cmd(3'd0, 32'h0, n, d);
      check($sformatf("R%0d latency vec %0d", VECS[i].req, i),
            32'(n), 32'(VECS[i].lat));
      check($sformatf("R2/R%0d HI vec %0d", VECS[i].req, i), d, VECS[i].hi);
      hold_cmd(3'd1, 32'h0, n, d);
      check($sformatf("R2/R%0d LO vec %0d", VECS[i].req, i), d, VECS[i].lo);
      check($sformatf("R8 no stall after done vec %0d", i), 32'(n), 32'd0);
    end

    // R9: direct writes while idle
    hold_cmd(3'd2, 32'h12345678, n, d);
    hold_cmd(3'd3, 32'h9ABCDEF0, n, d);
    hold_cmd(3'd0, 32'h0, n, d);
    check("R9 HI direct write", d, 32'h12345678);
    hold_cmd(3'd1, 32'h0, n, d);
    check("R9 LO direct write", d, 32'h9ABCDEF0);

    // R8/R9: write held through a running multiply, applied after commit
    issue(3'd5, 32'h3, 32'h5);
    hold_cmd(3'd2, 32'h0000AAAA, n, d);
    check("R8 write stall count", 32'(n), 32'd6);
    hold_cmd(3'd0, 32'h0, n, d);
    check("R9 HI after held write", d, 32'h0000AAAA);
    hold_cmd(3'd1, 32'h0, n, d);
    check("R9 LO keeps product", d, 32'h0000000F);

    // R10: multiply cuts into a divide two cycles after it began
    issue(3'd7, 32'd100, 32'd7);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = 3'd5;
    rs       = 32'h7;
    rt       = 32'h6;
    #1;
    check("R10 arithmetic not stalled", 32'(stall), 32'd0);
    @(negedge clk);
    op_valid = 1'b0;
    hold_cmd(3'd1, 32'h0, n, d);
    check("R10 restarted latency", 32'(n), 32'd6);
    check("R10 LO from new op", d, 32'd42);
    hold_cmd(3'd0, 32'h0, n, d);
    check("R10 HI from new op", d, 32'd0);

    // R8: no stall once idle, busy low
    #1;
    check("R8 busy low when idle", 32'(busy), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule